// File: doc/BRIEF.md
# Flash Status Byte Generator

This block forms the byte that a flash memory puts on its data bus when it is read while its embedded program/erase sequencer is busy, or while an erase is on hold. A program or erase engine elsewhere drives the current operation mode and the error events. Address decoding supplies a flag that says whether the read address lies in a region selected for erase. The block combines these inputs with its own small amount of state: two read-driven toggle flops, a sticky error flag, the bit 7 value of the last program and the kind of the last operation. From these it produces the status byte with each flag in its fixed bit position.

A read is signalled by a synchronous read strobe. Each rising edge of that strobe is one read. The toggle flops advance on read edges and not on clock cycles. While the device is busy, two back-to-back reads therefore always show complementary toggle values, however many clocks pass between them. When erase is suspended and the read falls outside the suspended region, the block passes the array data input through unchanged.

Top module: `flash_status_gen`

## Requirements
- R1: Output bits 0, 1 and 4 are always 0, except for an out-of-region read during suspend (mode 2'b11), which R8 covers.
- R2: In program mode (mode 2'b01), bit 7 is the complement of bit 7 of the program data captured on the last `prog_start_i` cycle.
- R3: In idle mode (mode 2'b00), bit 7 depends on the last busy mode seen. After a program it is the captured program bit 7. After an erase it is 1. Before any operation it is 0. In idle mode bit 2 is 1 and bit 3 is 0.
- R4: In erase mode (mode 2'b10), bit 7 is 0.
- R5: Bit 6 inverts once per rising edge of `rd_i` while the mode is program or erase. A strobe held high counts as one read. In idle mode bit 6 holds its value.
- R6: Bit 2 reads 1 in program and idle modes. In erase mode it reads 1 outside the erase region and inverts on each read edge inside it. When `chip_erase_i` is 1, every address counts as inside the erase region.
- R7: In suspend mode, a read inside the erase region returns bit 7 = 1 and bit 6 = 1. Bit 2 inverts on each read edge, bit 5 shows the error flag and bit 3 is 0.
- R8: In suspend mode, a read outside the erase region returns `array_data_i` unchanged on all 8 bits.
- R9: The error flag (bit 5) is set by `fail_i` and stays set until `clr_i`. If set and clear arrive in the same cycle, set wins.
- R10: A `prog_start_i` whose program data has a 1 where `cell_data_i` has a 0 sets the error flag.
- R11: In erase mode, bit 3 is 0 while `tmo_run_i` is 1 and 1 once it drops. In every mode other than erase, bit 3 is 0.
- R12: After reset the toggles and the error flag are 0 and no operation is recorded, so an idle read gives 8'h04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode: 00 idle, 01 program, 10 erase, 11 erase suspended |
| blk_sel_i | input | 1 | Read address lies in a block selected for erase |
| chip_erase_i | input | 1 | Chip-wide erase: every address counts as selected |
| rd_i | input | 1 | Synchronous read strobe; a rising edge is one read |
| prog_start_i | input | 1 | One-cycle pulse that starts a program |
| prog_data_i | input | 8 | Data to be programmed, sampled on `prog_start_i` |
| cell_data_i | input | 8 | Present content of the target cell, sampled on `prog_start_i` |
| fail_i | input | 1 | Program or erase failure event |
| clr_i | input | 1 | Read/reset command; clears the error flag |
| tmo_run_i | input | 1 | Multi-block erase timeout still running |
| array_data_i | input | 8 | Array data for reads outside the erase region |
| status_o | output | 8 | Status byte or passed-through array data |

## Verification
The situations hardest to reach from the ports are the ones where the toggle flops must hold. This happens when a read strobe stays high for several clocks, when reads occur in idle mode, and when reads fall outside the erase region in erase mode, where bit 6 must advance but bit 2 must not. The stimulus holds the strobe high over several cycles. It mixes in-region and out-of-region reads in erase mode and in suspend mode. It then returns to idle and reads again, so that a held toggle value is seen directly on the status byte. Error handling is driven with simultaneous set and clear and with a program that would turn a 0 into a 1.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_PROG = 2'b01,
    MODE_ERASE = 2'b10,
    MODE_SUSP = 2'b11
  } fs_mode_e;

  typedef enum logic [1:0] {
    LAST_NONE = 2'b00,
    LAST_PROG = 2'b01,
    LAST_ERASE = 2'b10
  } fs_last_e;

  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TGL_A = 6;
  localparam int unsigned BIT_ERR = 5;
  localparam int unsigned BIT_TMR = 3;
  localparam int unsigned BIT_TGL_B = 2;
endpackage

// File: rtl/fsg_read_toggle.sv
module fsg_read_toggle #(
  parameter int unsigned N_TGL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [N_TGL-1:0] en_i,
  output logic [N_TGL-1:0] tgl_o
);
  logic rd_q;
  logic rd_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_i;
  end

  assign rd_rise = rd_i & ~rd_q;

  for (genvar g = 0; g < N_TGL; g++) begin : g_tgl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 tgl_o[g] <= 1'b0;
      else if (rd_rise && en_i[g]) tgl_o[g] <= ~tgl_o[g];
    end
  end
endmodule

// File: rtl/fsg_err_track.sv
module fsg_err_track #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  prog_start_i,
  input  logic [DATA_W-1:0]     prog_data_i,
  input  logic [DATA_W-1:0]     cell_data_i,
  input  logic                  fail_i,
  input  logic                  clr_i,
  input  flash_status_pkg::fs_mode_e mode_i,
  output logic                  err_o,
  output logic                  pbit_o,
  output flash_status_pkg::fs_last_e last_o
);
  import flash_status_pkg::*;

  logic zero_to_one;
  assign zero_to_one = prog_start_i & (|(prog_data_i & ~cell_data_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= 1'b0;
      pbit_o <= 1'b0;
      last_o <= LAST_NONE;
    end else begin
      if (fail_i || zero_to_one) err_o <= 1'b1;
      else if (clr_i)            err_o <= 1'b0;
      if (prog_start_i) pbit_o <= prog_data_i[BIT_POLL];
      if (mode_i == MODE_PROG)       last_o <= LAST_PROG;
      else if (mode_i == MODE_ERASE) last_o <= LAST_ERASE;
    end
  end
endmodule

// File: rtl/fsg_out_mux.sv
module fsg_out_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  flash_status_pkg::fs_mode_e mode_i,
  input  flash_status_pkg::fs_last_e last_i,
  input  logic              in_region_i,
  input  logic              tgl_a_i,
  input  logic              tgl_b_i,
  input  logic              err_i,
  input  logic              pbit_i,
  input  logic              tmo_run_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] status_o
);
  import flash_status_pkg::*;

  always_comb begin
    status_o = '0;
    status_o[BIT_ERR] = err_i;
    unique case (mode_i)
      MODE_PROG: begin
        status_o[BIT_POLL]  = ~pbit_i;
        status_o[BIT_TGL_A] = tgl_a_i;
        status_o[BIT_TGL_B] = 1'b1;
      end
      MODE_ERASE: begin
        status_o[BIT_POLL]  = 1'b0;
        status_o[BIT_TGL_A] = tgl_a_i;
        status_o[BIT_TGL_B] = in_region_i ? tgl_b_i : 1'b1;
        status_o[BIT_TMR]   = ~tmo_run_i;
      end
      MODE_SUSP: begin
        if (in_region_i) begin
          status_o[BIT_POLL]  = 1'b1;
          status_o[BIT_TGL_A] = 1'b1;
          status_o[BIT_TGL_B] = tgl_b_i;
        end else begin
          status_o = array_data_i;
        end
      end
      default: begin
        status_o[BIT_POLL]  = (last_i == LAST_ERASE) ? 1'b1 :
                              (last_i == LAST_PROG) ? pbit_i : 1'b0;
        status_o[BIT_TGL_A] = tgl_a_i;
        status_o[BIT_TGL_B] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              blk_sel_i,
  input  logic              chip_erase_i,
  input  logic              rd_i,
  input  logic              prog_start_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic [DATA_W-1:0] cell_data_i,
  input  logic              fail_i,
  input  logic              clr_i,
  input  logic              tmo_run_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] status_o
);
  import flash_status_pkg::*;

  localparam int unsigned N_TGL = 2;

  fs_mode_e   mode;
  fs_last_e   last_op;
  logic       in_region;
  logic [N_TGL-1:0] tgl_en, tgl;
  logic       err, pbit;

  assign mode      = fs_mode_e'(mode_i);
  assign in_region = blk_sel_i | chip_erase_i;
  // index 0: bit 6 source, index 1: bit 2 source
  assign tgl_en[0] = (mode == MODE_PROG) | (mode == MODE_ERASE);
  assign tgl_en[1] = ((mode == MODE_ERASE) | (mode == MODE_SUSP)) & in_region;

  fsg_read_toggle #(.N_TGL(N_TGL)) u_tgl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rd_i  (rd_i),
    .en_i  (tgl_en),
    .tgl_o (tgl)
  );

  fsg_err_track #(.DATA_W(DATA_W)) u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_start_i(prog_start_i),
    .prog_data_i (prog_data_i),
    .cell_data_i (cell_data_i),
    .fail_i      (fail_i),
    .clr_i       (clr_i),
    .mode_i      (mode),
    .err_o       (err),
    .pbit_o      (pbit),
    .last_o      (last_op)
  );

  fsg_out_mux #(.DATA_W(DATA_W)) u_mux (
    .mode_i      (mode),
    .last_i      (last_op),
    .in_region_i (in_region),
    .tgl_a_i     (tgl[0]),
    .tgl_b_i     (tgl[1]),
    .err_i       (err),
    .pbit_i      (pbit),
    .tmo_run_i   (tmo_run_i),
    .array_data_i(array_data_i),
    .status_o    (status_o)
  );
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              blk_sel_i,
  input logic              chip_erase_i,
  input logic              rd_i,
  input logic              prog_start_i,
  input logic [DATA_W-1:0] prog_data_i,
  input logic              fail_i,
  input logic              clr_i,
  input logic              tmo_run_i,
  input logic [DATA_W-1:0] status_o
);
  logic rd_prev;
  logic visible;
  logic in_reg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_prev <= 1'b0;
    else         rd_prev <= rd_i;
  end

  assign in_reg  = blk_sel_i | chip_erase_i;
  assign visible = !(mode_i == 2'b11 && !in_reg);

  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    visible |-> (status_o[0] == 1'b0 && status_o[1] == 1'b0 && status_o[4] == 1'b0));

  assert_prog_poll_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_i && mode_i == 2'b01) |=>
      (mode_i != 2'b01 || status_o[7] == !$past(prog_data_i[7])));

  assert_erase_poll_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> (status_o[7] == 1'b0));

  assert_busy_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rd_prev && (mode_i == 2'b01 || mode_i == 2'b10)) |=>
      (mode_i != $past(mode_i) || status_o[6] != $past(status_o[6])));

  assert_susp_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && in_reg) |-> (status_o[7] && status_o[6] && !status_o[3]));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (visible && status_o[5] && !clr_i) |=> (!visible || status_o[5]));

  assert_timer_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10 && visible) |-> (status_o[3] == 1'b0));
endmodule

bind flash_status_gen flash_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .blk_sel_i   (blk_sel_i),
  .chip_erase_i(chip_erase_i),
  .rd_i        (rd_i),
  .prog_start_i(prog_start_i),
  .prog_data_i (prog_data_i),
  .fail_i      (fail_i),
  .clr_i       (clr_i),
  .tmo_run_i   (tmo_run_i),
  .status_o    (status_o)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       blk = 1'b0, chip = 1'b0, rd = 1'b0, pstart = 1'b0;
  logic [7:0] pdata = 8'h00, cdata = 8'hFF, adata = 8'h00;
  logic       fail = 1'b0, clr = 1'b0, tmo = 1'b0;
  logic [7:0] status;

  int n_tests = 0, n_fail = 0;
  string phase = "R12";

  // reference model state
  bit m_t6, m_t2, m_err, m_pbit, m_rdq;
  int m_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen u_flash_status_gen (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .blk_sel_i(blk),
    .chip_erase_i(chip), .rd_i(rd), .prog_start_i(pstart),
    .prog_data_i(pdata), .cell_data_i(cdata), .fail_i(fail), .clr_i(clr),
    .tmo_run_i(tmo), .array_data_i(adata), .status_o(status)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t6 = 0; m_t2 = 0; m_err = 0; m_pbit = 0; m_rdq = 0; m_last = 0;
    end else begin
      bit rise, inr;
      rise = rd && !m_rdq;
      inr  = blk || chip;
      if (rise && (mode == 2'd1 || mode == 2'd2)) m_t6 = !m_t6;
      if (rise && (mode == 2'd2 || mode == 2'd3) && inr) m_t2 = !m_t2;
      if (fail || (pstart && ((pdata & ~cdata) != 8'h00))) m_err = 1;
      else if (clr) m_err = 0;
      if (pstart) m_pbit = pdata[7];
      if (mode == 2'd1) m_last = 1;
      else if (mode == 2'd2) m_last = 2;
      m_rdq = rd;
    end
  end

  function automatic logic [7:0] expect_byte();
    logic [7:0] e;
    bit inr;
    inr = blk || chip;
    e = 8'h00;
    e[5] = m_err;
    case (mode)
      2'd1: begin e[7] = !m_pbit; e[6] = m_t6; e[2] = 1; end
      2'd2: begin e[7] = 0; e[6] = m_t6; e[2] = inr ? m_t2 : 1'b1; e[3] = !tmo; end
      2'd3: if (inr) begin e[7] = 1; e[6] = 1; e[2] = m_t2; end
            else e = adata;
      default: begin
        e[7] = (m_last == 2) ? 1'b1 : (m_last == 1) ? m_pbit : 1'b0;
        e[6] = m_t6; e[2] = 1;
      end
    endcase
    return e;
  endfunction

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      @(negedge clk);
      e = expect_byte();
      n_tests++;
      if (status !== e) begin
        n_fail++;
        $display("FAIL %s: status=%h expected=%h at %0t", phase, status, e, $time);
      end
    end
  endtask

  task automatic read_pulse(int hold = 1);
    rd = 1; tick(hold);
    rd = 0; tick(1);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    phase = "R12";
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick(2);
    n_tests++;
    if (status !== 8'h04) begin
      n_fail++;
      $display("FAIL R12: status=%h expected=04", status);
    end

    phase = "R1";
    adata = 8'hFF; tmo = 1; read_pulse(); tick(1);

    phase = "R2";
    mode = 2'd1; pdata = 8'h80; cdata = 8'hFF; pstart = 1; tick(1);
    pstart = 0; tick(1);
    phase = "R5";
    read_pulse(); read_pulse(3); read_pulse();
    phase = "R3";
    mode = 2'd0; tick(2);
    phase = "R5";
    read_pulse(); read_pulse();

    phase = "R10";
    mode = 2'd1; pdata = 8'h01; cdata = 8'h00; pstart = 1; tick(1);
    pstart = 0; tick(1);
    mode = 2'd0; tick(1);
    phase = "R9";
    tick(3); clr = 1; tick(1); clr = 0; tick(1);
    fail = 1; clr = 1; tick(1); fail = 0; clr = 0; tick(2);
    clr = 1; tick(1); clr = 0;
    fail = 1; tick(1); fail = 0; tick(2); clr = 1; tick(1); clr = 0; tick(1);

    phase = "R11";
    mode = 2'd2; tmo = 1; tick(2); tmo = 0; tick(2);
    phase = "R4";
    blk = 1; read_pulse(); read_pulse(2);
    phase = "R6";
    blk = 0; read_pulse(); read_pulse();
    chip = 1; read_pulse(); read_pulse(); chip = 0;
    blk = 1; read_pulse();

    phase = "R7";
    mode = 2'd3; read_pulse(); read_pulse(); tick(1);
    fail = 1; tick(1); fail = 0; tick(1);
    phase = "R8";
    blk = 0; adata = 8'hA5; read_pulse(); adata = 8'h5A; tick(1);
    chip = 1; phase = "R7"; read_pulse(); chip = 0;

    phase = "R3";
    mode = 2'd0; clr = 1; tick(1); clr = 0; tick(2);
    read_pulse();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule